// File: doc/BRIEF.md
# Interrupt Entry Stacking Sequencer

This block drives the bus of an 8-bit processor core while it enters an exception. When a hardware interrupt request arrives with the global mask clear, or when the instruction decoder raises a software-interrupt trigger, the sequencer captures the return address, the index byte, the accumulator, the condition code byte, the stack pointer and the vector address in one cycle. It then owns the byte-wide bus until the entry is complete.

It writes the context onto a stack that grows downward, one byte per cycle. It sets the mask bit in its copy of the condition codes once that byte is on the stack, and reads the two-byte vector, high byte first. It then leaves the bus idle for one cycle and reads three bytes from the vector target into the instruction queue. A one-cycle completion pulse tells the core that the new program counter, stack pointer, condition codes and queue are valid.

Read data is taken in the same cycle as the read strobe. The upper index byte is never written, so a handler that uses it must save it itself.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the write and read strobes and the done flag are low, and the stack pointer, condition code, program counter and queue outputs are all zero.
- R2: While idle, a hardware request is taken only when bit 3 (the mask bit) of `ccr_in` is 0. With that bit set, the request causes no bus access and no done pulse.
- R3: A software trigger seen while idle is taken whatever the value of the mask bit.
- R4: In the five cycles after a request is taken, the block writes low return byte, high return byte, index byte, accumulator, condition code byte. The addresses are SP, SP-1, SP-2, SP-3, SP-4, taken modulo 65536, where SP is the `sp_in` value at acceptance.
- R5: The stacked bytes, the stack addresses and the vector address are those sampled at acceptance. Input changes later in the sequence do not alter them.
- R6: The stacked condition code byte holds the mask bit as it was at acceptance. From the cycle after that write, `ccr_out` equals that byte with bit 3 set. At completion `sp_out` equals SP-5 modulo 65536.
- R7: After the stacking, one read is made at the vector address and one at vector address + 1 (modulo 65536). `pc_out` is {first byte, second byte}.
- R8: Exactly one cycle with neither strobe follows the second vector read.
- R9: Three reads then follow at the target, target+1 and target+2. `queue_out[7:0]`, `[15:8]` and `[23:16]` hold those bytes in that order.
- R10: `done` is high for exactly one cycle, the cycle after the third queue read. A request held through the sequence is taken no earlier than the cycle after `done`, so the next write starts two cycles after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Hardware interrupt request |
| swi_trig | input | 1 | Software interrupt trigger from the decoder |
| pc_ret | input | 16 | Return address to stack |
| x_in | input | 8 | Index register low byte |
| a_in | input | 8 | Accumulator |
| ccr_in | input | 8 | Condition code byte; bit 3 is the mask |
| sp_in | input | 16 | Current stack pointer |
| vec_addr | input | 16 | Address of the vector's high byte |
| rd_data | input | 8 | Bus read data, valid in the strobe cycle |
| bus_addr | output | 16 | Bus address |
| wr_data | output | 8 | Bus write data |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| sp_out | output | 16 | Updated stack pointer |
| ccr_out | output | 8 | Updated condition codes |
| pc_out | output | 16 | Vector target (new program counter) |
| queue_out | output | 24 | Prefetched instruction bytes |
| done | output | 1 | One-cycle completion pulse |

## Verification
Entries are run with a cleared mask and a hardware request, and with the mask set and a software trigger. Comparing the two shows that only the hardware path is gated by the mask. In a further case a masked hardware request is held for several cycles and must leave the bus quiet. Every context byte is distinct, and all inputs are inverted right after acceptance, so a swapped push order or a live path from the inputs shows up as a wrong byte. A stack pointer near zero and a vector at the top of memory exercise the address wrap. A trigger held across the whole sequence shows whether a second entry starts too early.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    parameter int unsigned ADDR_W    = 16;
    parameter int unsigned DATA_W    = 8;
    parameter int unsigned PUSH_CNT  = 5;
    parameter int unsigned FILL_CNT  = 3;
    localparam int unsigned IDX_W    = $clog2(PUSH_CNT);
    localparam int unsigned QUEUE_W  = FILL_CNT * DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_GAP,
        ST_FILL,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   sp;
        logic [ADDR_W-1:0]   ret;
        logic [DATA_W-1:0]   xr;
        logic [DATA_W-1:0]   ar;
        logic [DATA_W-1:0]   ccr;
        logic [ADDR_W-1:0]   vec;
        logic [ADDR_W-1:0]   tgt;
        logic [QUEUE_W-1:0]  queue;
        logic                done;
    } seq_regs_t;

endpackage

// File: rtl/irq_ctx_mux.sv
module irq_ctx_mux
    import irq_entry_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    input  logic [ADDR_W-1:0]  ret,
    input  logic [DATA_W-1:0]  xr,
    input  logic [DATA_W-1:0]  ar,
    input  logic [DATA_W-1:0]  ccr,
    output logic [DATA_W-1:0]  push_byte
);

    // Push order is behaviour: return low, return high, index, accumulator, flags.
    logic [DATA_W-1:0] slot [PUSH_CNT];

    always_comb begin
        slot[0] = ret[DATA_W-1:0];
        slot[1] = ret[ADDR_W-1:DATA_W];
        slot[2] = xr;
        slot[3] = ar;
        slot[4] = ccr;
    end

    always_comb begin
        push_byte = '0;
        for (int k = 0; k < PUSH_CNT; k++) begin
            if (idx == IDX_W'(k)) push_byte = slot[k];
        end
    end

endmodule

// File: rtl/irq_bus_drv.sv
module irq_bus_drv
    import irq_entry_pkg::*;
(
    input  seq_state_e         state,
    input  logic [IDX_W-1:0]   idx,
    input  logic [ADDR_W-1:0]  sp,
    input  logic [ADDR_W-1:0]  vec,
    input  logic [ADDR_W-1:0]  tgt,
    input  logic [DATA_W-1:0]  push_byte,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               rd_en,
    output logic               wr_en
);

    always_comb begin
        bus_addr = '0;
        wr_data  = '0;
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        unique case (state)
            ST_PUSH: begin
                bus_addr = sp;
                wr_data  = push_byte;
                wr_en    = 1'b1;
            end
            ST_VEC_HI: begin
                bus_addr = vec;
                rd_en    = 1'b1;
            end
            ST_VEC_LO: begin
                bus_addr = vec + ADDR_W'(1);
                rd_en    = 1'b1;
            end
            ST_FILL: begin
                bus_addr = tgt + ADDR_W'(idx);
                rd_en    = 1'b1;
            end
            default: begin
                bus_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_fill_q.sv
module irq_fill_q
    import irq_entry_pkg::*;
(
    input  logic               load,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [QUEUE_W-1:0] q_in,
    output logic [QUEUE_W-1:0] q_out
);

    for (genvar g = 0; g < FILL_CNT; g++) begin : g_slot
        assign q_out[g*DATA_W +: DATA_W] =
            (load && (idx == IDX_W'(g))) ? rd_data : q_in[g*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned I_BIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_req,
    input  logic               swi_trig,
    input  logic [15:0]        pc_ret,
    input  logic [7:0]         x_in,
    input  logic [7:0]         a_in,
    input  logic [7:0]         ccr_in,
    input  logic [15:0]        sp_in,
    input  logic [15:0]        vec_addr,
    input  logic [7:0]         rd_data,
    output logic [15:0]        bus_addr,
    output logic [7:0]         wr_data,
    output logic               rd_en,
    output logic               wr_en,
    output logic [15:0]        sp_out,
    output logic [7:0]         ccr_out,
    output logic [15:0]        pc_out,
    output logic [23:0]        queue_out,
    output logic               done
);

    localparam logic [IDX_W-1:0] PUSH_LAST = IDX_W'(PUSH_CNT - 1);
    localparam logic [IDX_W-1:0] FILL_LAST = IDX_W'(FILL_CNT - 1);

    seq_regs_t r_q;
    seq_regs_t r_d;

    logic [DATA_W-1:0]  push_byte;
    logic [QUEUE_W-1:0] q_next;
    logic               take;
    logic               seq_busy;

    irq_ctx_mux u_mux (
        .idx       (r_q.idx),
        .ret       (r_q.ret),
        .xr        (r_q.xr),
        .ar        (r_q.ar),
        .ccr       (r_q.ccr),
        .push_byte (push_byte)
    );

    irq_bus_drv u_bus (
        .state     (r_q.state),
        .idx       (r_q.idx),
        .sp        (r_q.sp),
        .vec       (r_q.vec),
        .tgt       (r_q.tgt),
        .push_byte (push_byte),
        .bus_addr  (bus_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

    irq_fill_q u_fill (
        .load    (r_q.state == ST_FILL),
        .idx     (r_q.idx),
        .rd_data (rd_data),
        .q_in    (r_q.queue),
        .q_out   (q_next)
    );

    assign take     = swi_trig || (irq_req && !ccr_in[I_BIT]);
    assign seq_busy = (r_q.state != ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (take) begin
                    r_d.state = ST_PUSH;
                    r_d.idx   = '0;
                    r_d.sp    = sp_in;
                    r_d.ret   = pc_ret;
                    r_d.xr    = x_in;
                    r_d.ar    = a_in;
                    r_d.ccr   = ccr_in;
                    r_d.vec   = vec_addr;
                end
            end
            ST_PUSH: begin
                r_d.sp = r_q.sp - ADDR_W'(1);
                if (r_q.idx == PUSH_LAST) begin
                    r_d.ccr[I_BIT] = 1'b1;
                    r_d.idx        = '0;
                    r_d.state      = ST_VEC_HI;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_VEC_HI: begin
                r_d.tgt[ADDR_W-1:DATA_W] = rd_data;
                r_d.state                = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                r_d.tgt[DATA_W-1:0] = rd_data;
                r_d.state           = ST_GAP;
            end
            ST_GAP: begin
                r_d.idx   = '0;
                r_d.state = ST_FILL;
            end
            ST_FILL: begin
                r_d.queue = q_next;
                if (r_q.idx == FILL_LAST) begin
                    r_d.done  = 1'b1;
                    r_d.idx   = '0;
                    r_d.state = ST_DONE;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_out    = r_q.sp;
    assign ccr_out   = r_q.ccr;
    assign pc_out    = r_q.tgt;
    assign queue_out = r_q.queue;
    assign done      = r_q.done;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int unsigned I_BIT = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic        swi_trig,
    input logic [7:0]  ccr_in,
    input logic [15:0] bus_addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  ccr_out,
    input logic        done,
    input logic        busy
);

    // R4: a push and a read never share a cycle
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R4: back-to-back pushes step down by one byte
    a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (bus_addr == $past(bus_addr) - 16'd1));

    // R2: masked hardware request while idle starts nothing
    a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && !swi_trig && ccr_in[I_BIT]) |=> !wr_en);

    // R3: software trigger while idle always starts stacking
    a_r3_swi_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && swi_trig) |=> wr_en);

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no bus access in the completion cycle
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !rd_en));

    // R6: mask is set by the time the sequence completes
    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ccr_out[I_BIT]);

endmodule

bind irq_entry_seq irq_entry_chk #(.I_BIT(I_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .swi_trig (swi_trig),
    .ccr_in   (ccr_in),
    .bus_addr (bus_addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .ccr_out  (ccr_out),
    .done     (done),
    .busy     (seq_busy)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req, swi_trig;
    logic [15:0] pc_ret, sp_in, vec_addr;
    logic [7:0]  x_in, a_in, ccr_in, rd_data;
    logic [15:0] bus_addr, sp_out, pc_out;
    logic [7:0]  wr_data, ccr_out;
    logic        rd_en, wr_en, done;
    logic [23:0] queue_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_trig(swi_trig),
        .pc_ret(pc_ret), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
        .sp_in(sp_in), .vec_addr(vec_addr), .rd_data(rd_data),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_en(rd_en), .wr_en(wr_en),
        .sp_out(sp_out), .ccr_out(ccr_out), .pc_out(pc_out),
        .queue_out(queue_out), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] ad);
        return ad[7:0] ^ ad[15:8] ^ 8'h5A;
    endfunction

    always_comb rd_data = mem_byte(bus_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        bit          wr;
        bit          rd;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } bus_op_t;

    // Drives a request at the current negedge and checks twelve following cycles.
    task automatic run_entry(input bit use_swi, input logic [7:0] ccr0,
                             input logic [15:0] sp0, input logic [15:0] pc0,
                             input logic [15:0] vec0, input logic [7:0] x0,
                             input logic [7:0] a0, input bit hold_req);
        bus_op_t     ops[$];
        logic [7:0]  pushed [5];
        logic [15:0] tgt;
        logic [23:0] qexp;
        pushed[0] = pc0[7:0]; pushed[1] = pc0[15:8]; pushed[2] = x0;
        pushed[3] = a0;       pushed[4] = ccr0;
        for (int k = 0; k < 5; k++)
            ops.push_back('{1'b1, 1'b0, sp0 - 16'(k), pushed[k], "R4/R5 push"});
        ops.push_back('{1'b0, 1'b1, vec0, 8'h00, "R7 vec hi"});
        ops.push_back('{1'b0, 1'b1, vec0 + 16'd1, 8'h00, "R7 vec lo"});
        ops.push_back('{1'b0, 1'b0, 16'h0, 8'h00, "R8 gap"});
        tgt = {mem_byte(vec0), mem_byte(vec0 + 16'd1)};
        for (int k = 0; k < 3; k++) begin
            ops.push_back('{1'b0, 1'b1, tgt + 16'(k), 8'h00, "R9 fill"});
            qexp[k*8 +: 8] = mem_byte(tgt + 16'(k));
        end
        ops.push_back('{1'b0, 1'b0, 16'h0, 8'h00, "R10 done"});

        pc_ret = pc0; x_in = x0; a_in = a0; ccr_in = ccr0; sp_in = sp0; vec_addr = vec0;
        irq_req = !use_swi; swi_trig = use_swi;
        for (int step = 0; step < 12; step++) begin
            bus_op_t e;
            @(negedge clk);
            e = ops[step];
            chk(wr_en == e.wr, {e.req, " wr_en"}, 32'(wr_en), 32'(e.wr));
            chk(rd_en == e.rd, {e.req, " rd_en"}, 32'(rd_en), 32'(e.rd));
            if (e.wr || e.rd)
                chk(bus_addr == e.addr, {e.req, " addr"}, 32'(bus_addr), 32'(e.addr));
            if (e.wr)
                chk(wr_data == e.data, {e.req, " data"}, 32'(wr_data), 32'(e.data));
            chk(done == (step == 11), "R10 done timing", 32'(done), 32'(step == 11));
            if (step == 4)
                chk(ccr_out == ccr0, "R6 ccr before push", 32'(ccr_out), 32'(ccr0));
            if (step == 5)
                chk(ccr_out == (ccr0 | 8'h08), "R6 mask set", 32'(ccr_out), 32'(ccr0 | 8'h08));
            if (step == 11) begin
                chk(sp_out == sp0 - 16'd5, "R6 sp_out", 32'(sp_out), 32'(sp0 - 16'd5));
                chk(pc_out == tgt, "R7 pc_out", 32'(pc_out), 32'(tgt));
                chk(queue_out == qexp, "R9 queue", 32'(queue_out), 32'(qexp));
                chk(ccr_out == (ccr0 | 8'h08), "R6 final ccr", 32'(ccr_out), 32'(ccr0 | 8'h08));
            end
            if (step == 0) begin
                // R5: disturb every input after acceptance
                pc_ret = ~pc0; x_in = ~x0; a_in = ~a0; ccr_in = ~ccr0;
                sp_in = ~sp0; vec_addr = ~vec0;
                if (!hold_req) begin
                    irq_req = 1'b0; swi_trig = 1'b0;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = 1'b0; swi_trig = 1'b0;
        pc_ret = '0; x_in = '0; a_in = '0; ccr_in = '0; sp_in = '0; vec_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!wr_en && !rd_en, "R1 strobes", {wr_en, rd_en}, 0);
        chk(!done, "R1 done", 32'(done), 0);
        chk(sp_out == 0 && ccr_out == 0 && pc_out == 0 && queue_out == 0,
            "R1 outputs", 32'(queue_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: masked hardware request is ignored
        ccr_in = 8'h08; irq_req = 1'b1; sp_in = 16'h0123;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!wr_en && !rd_en, "R2 masked no access", {wr_en, rd_en}, 0);
            chk(!done, "R2 masked no done", 32'(done), 0);
        end
        chk(sp_out == 16'h0000, "R2 sp untouched", 32'(sp_out), 0);
        irq_req = 1'b0;
        @(negedge clk);

        // R2/R4: unmasked hardware entry
        run_entry(1'b0, 8'h00, 16'h01FF, 16'hC123, 16'h1230, 8'h44, 8'h55, 1'b0);
        @(negedge clk);

        // R3: software trigger with mask set; R4 wrap of stack, R7 vector wrap
        run_entry(1'b1, 8'hFF, 16'h0002, 16'hBEEF, 16'hFFFF, 8'h9A, 8'h3C, 1'b0);
        @(negedge clk);

        // R4 wrap with hardware path, other flags set, mask clear
        run_entry(1'b0, 8'hF7, 16'h0001, 16'h7E01, 16'hFFFE, 8'h12, 8'hE0, 1'b0);
        @(negedge clk);

        // R10: trigger held through the sequence
        run_entry(1'b1, 8'h2A, 16'h0400, 16'h0F0E, 16'h2000, 8'hA5, 8'h5A, 1'b1);
        @(negedge clk);
        chk(!wr_en && !rd_en, "R10 no restart in idle cycle", {wr_en, rd_en}, 0);
        @(negedge clk);
        chk(wr_en == 1'b1, "R10 restart after done", 32'(wr_en), 1);
        swi_trig = 1'b0;
        repeat (12) @(negedge clk);
        chk(!wr_en && !rd_en && !done, "R10 back to idle", {wr_en, rd_en, done}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule